// File: doc/BRIEF.md
# Frame-Credit Packet Injection Controller

This block regulates one traffic flow at its source. Each new packet is tagged with a frame number, and the block enforces a flit allowance for each frame. The frames form a circular window of `W` entries. The oldest entry is the head frame, which drains with top priority, and the flow may not place new packets into it. The block holds a signed credit balance and an injection frame. Credit is spent in whole packets, so one long packet can leave the balance below zero. When the balance is used up, the controller borrows the reservation of later frames, one frame at a time. It stops borrowing before it would wrap onto the head frame.

A requester presents `req_i` with a length and holds it until `acc_o` rises. The accepted tag on `tag_o` travels with the packet into a source queue outside this block. A window-shift pulse carries the new head frame. It recycles the oldest frame, and it may open credit for a flow that was blocked. Best-effort packets skip regulation and carry the out-of-window value `W`, the lowest priority. The per-frame reservation can be rewritten at run time, and a new value takes effect only at the next window shift.

Top module: `fcr_inject_ctrl`

## Requirements
- R1: After reset the head frame is 0, the injection frame is 1, and both the active reservation and the credit balance equal `RSV_INIT`.
- R2: A regulated request (`be_i`=0) made while the credit is strictly positive is accepted in the same cycle (`acc_o`=1, `stall_o`=0) with `tag_o` equal to the injection frame. Its full length is then subtracted from the credit.
- R3: A regulated request made while the credit is zero or negative is not accepted and raises `stall_o`. If no shift is present in that cycle and the next frame (injection frame + 1 mod `W`) is not the head frame, the injection frame moves to that next frame and the reservation is added to the credit. Only one such step is taken per cycle.
- R4: The controller never steps onto the head frame. When the next frame equals the head frame, it stays stalled with the injection frame and credit unchanged until a window shift.
- R5: On `shift_i` the head frame takes the value of `head_i`. If that value equals the injection frame, the injection frame advances by one mod `W` and the credit becomes min(reservation, credit + reservation).
- R6: `tag_o` is `$clog2(W+1)` bits wide. On a regulated acceptance it is always below `W`.
- R7: A best-effort request (`be_i`=1) is accepted in the same cycle regardless of credit, with `tag_o` = `W`. It leaves the credit and the injection frame unchanged.
- R8: A reservation written through `rsv_we_i`/`rsv_i` is held pending. It becomes the active reservation at the first `shift_i` after the write cycle, and that shift's credit update already uses the new value.
- R9: Packet lengths from 1 to `MAX_LEN` are accepted. The credit never drops below 1 − `MAX_LEN` and never exceeds the active reservation bound.
- R10: `acc_o` and `stall_o` are never high together. A stalled request that is held is accepted without further action once credit is positive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Packet request, held until accepted |
| be_i | input | 1 | Request is best-effort |
| len_i | input | $clog2(MAX_LEN+1) | Packet length in flits (1..MAX_LEN) |
| shift_i | input | 1 | Window-shift pulse |
| head_i | input | $clog2(W) | New head frame, valid with shift_i |
| rsv_we_i | input | 1 | Reservation write strobe |
| rsv_i | input | $clog2(FRAME_FLITS+1) | New per-frame reservation in flits |
| acc_o | output | 1 | Request accepted this cycle |
| stall_o | output | 1 | Regulated request is waiting for credit |
| tag_o | output | $clog2(W+1) | Frame tag of the accepted packet |

## Verification
`acc_o`, `stall_o` and `tag_o` are combinational from the current state and request, so they are due in the same cycle as the request. The bench drives inputs just after the falling edge and compares one time unit later, before the rising edge commits the step. Credit, frame and reservation updates appear only one edge later. They are observed through the following cycle's accept/stall decision and tag, which includes the deferred reservation checked by comparing the behaviour before and after a shift.

// File: rtl/fcr_pkg.sv
package fcr_pkg;

  // circular increment within a window of m entries
  function automatic int unsigned wrap_inc(int unsigned v, int unsigned m);
    return (v + 1 >= m) ? 0 : v + 1;
  endfunction

  typedef enum logic [1:0] {
    ACT_IDLE = 2'd0,
    ACT_TAKE = 2'd1,
    ACT_STEP = 2'd2
  } credit_act_e;

endpackage

// File: rtl/fcr_rsv_reg.sv
module fcr_rsv_reg #(
  parameter int unsigned RW       = 5,
  parameter int unsigned RSV_INIT = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [RW-1:0] wdata_i,
  input  logic          shift_i,
  output logic [RW-1:0] rsv_o,
  output logic [RW-1:0] rsv_nxt_o
);
  logic [RW-1:0] act_q, pend_q;
  logic          pend_vld_q;

  assign rsv_o     = act_q;
  assign rsv_nxt_o = pend_vld_q ? pend_q : act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= RW'(RSV_INIT);
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
    end else begin
      if (shift_i) begin
        act_q      <= rsv_nxt_o;
        pend_vld_q <= 1'b0;
      end
      if (we_i) begin
        pend_q     <= wdata_i;
        pend_vld_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fcr_window.sv
module fcr_window
  import fcr_pkg::*;
#(
  parameter int unsigned W  = 4,
  parameter int unsigned FW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          shift_i,
  input  logic [FW-1:0] head_i,
  output logic [FW-1:0] inj_o,
  output logic [FW-1:0] head_o,
  output logic          blocked_o,
  output logic          wrap_o
);
  logic [FW-1:0] inj_q, head_q, inj_inc;

  assign inj_inc   = FW'(wrap_inc(int'(inj_q), W));
  assign blocked_o = (inj_inc == head_q);
  assign wrap_o    = shift_i && (head_i == inj_q);
  assign inj_o     = inj_q;
  assign head_o    = head_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      inj_q  <= FW'(1);
    end else begin
      if (shift_i) head_q <= head_i;
      if (wrap_o || step_i) inj_q <= inj_inc;
    end
  end
endmodule

// File: rtl/fcr_credit.sv
module fcr_credit
  import fcr_pkg::*;
#(
  parameter int unsigned CW       = 7,
  parameter int unsigned RW       = 5,
  parameter int unsigned LW       = 4,
  parameter int unsigned RSV_INIT = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  credit_act_e          act_i,
  input  logic [LW-1:0]        len_i,
  input  logic [RW-1:0]        rsv_i,
  input  logic                 wrap_i,
  input  logic [RW-1:0]        rsv_nxt_i,
  output logic signed [CW-1:0] credit_o,
  output logic                 pos_o
);
  logic signed [CW-1:0] credit_q, c_mid, c_wrap, len_s, rsv_s, rsvn_s;

  assign len_s  = $signed({{(CW-LW){1'b0}}, len_i});
  assign rsv_s  = $signed({{(CW-RW){1'b0}}, rsv_i});
  assign rsvn_s = $signed({{(CW-RW){1'b0}}, rsv_nxt_i});

  always_comb begin
    unique case (act_i)
      ACT_TAKE: c_mid = credit_q - len_s;
      ACT_STEP: c_mid = credit_q + rsv_s;
      default:  c_mid = credit_q;
    endcase
    c_wrap = c_mid + rsvn_s;
    if (c_wrap > rsvn_s) c_wrap = rsvn_s;
  end

  assign credit_o = credit_q;
  assign pos_o    = (credit_q > 0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) credit_q <= CW'(RSV_INIT);
    else         credit_q <= wrap_i ? c_wrap : c_mid;
  end
endmodule

// File: rtl/fcr_inject_ctrl.sv
module fcr_inject_ctrl
  import fcr_pkg::*;
#(
  parameter int unsigned W           = 4,
  parameter int unsigned FRAME_FLITS = 16,
  parameter int unsigned MAX_LEN     = 9,
  parameter int unsigned RSV_INIT    = 5,
  localparam int unsigned FW = (W > 1) ? $clog2(W) : 1,
  localparam int unsigned TW = $clog2(W + 1),
  localparam int unsigned LW = $clog2(MAX_LEN + 1),
  localparam int unsigned RW = $clog2(FRAME_FLITS + 1),
  localparam int unsigned CW = $clog2(FRAME_FLITS + MAX_LEN + 1) + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          be_i,
  input  logic [LW-1:0] len_i,
  input  logic          shift_i,
  input  logic [FW-1:0] head_i,
  input  logic          rsv_we_i,
  input  logic [RW-1:0] rsv_i,
  output logic          acc_o,
  output logic          stall_o,
  output logic [TW-1:0] tag_o
);
  logic                 qos_req, take, step, pos, blocked, wrap;
  logic [FW-1:0]        inj_q, head_q;
  logic [RW-1:0]        rsv_q, rsv_nxt;
  logic signed [CW-1:0] credit_q;
  credit_act_e          act;

  assign qos_req = req_i && !be_i;
  assign take    = qos_req && pos;
  // borrowing pauses on a shift cycle so the head copy is never stale
  assign step    = qos_req && !pos && !shift_i && !blocked;
  assign act     = take ? ACT_TAKE : (step ? ACT_STEP : ACT_IDLE);

  assign acc_o   = (req_i && be_i) || take;
  assign stall_o = qos_req && !pos;
  assign tag_o   = be_i ? TW'(W) : TW'(inj_q);

  fcr_rsv_reg #(.RW(RW), .RSV_INIT(RSV_INIT)) u_rsv (
    .clk_i, .rst_ni,
    .we_i(rsv_we_i), .wdata_i(rsv_i), .shift_i,
    .rsv_o(rsv_q), .rsv_nxt_o(rsv_nxt)
  );

  fcr_window #(.W(W), .FW(FW)) u_win (
    .clk_i, .rst_ni,
    .step_i(step), .shift_i, .head_i,
    .inj_o(inj_q), .head_o(head_q), .blocked_o(blocked), .wrap_o(wrap)
  );

  fcr_credit #(.CW(CW), .RW(RW), .LW(LW), .RSV_INIT(RSV_INIT)) u_crd (
    .clk_i, .rst_ni,
    .act_i(act), .len_i, .rsv_i(rsv_q),
    .wrap_i(wrap), .rsv_nxt_i(rsv_nxt),
    .credit_o(credit_q), .pos_o(pos)
  );
endmodule

// File: rtl/fcr_inject_chk.sv
module fcr_inject_chk #(
  parameter int unsigned W           = 4,
  parameter int unsigned FRAME_FLITS = 16,
  parameter int unsigned MAX_LEN     = 9,
  parameter int unsigned FW = 2,
  parameter int unsigned TW = 3,
  parameter int unsigned RW = 5,
  parameter int unsigned CW = 7
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 be_i,
  input logic                 shift_i,
  input logic [FW-1:0]        head_i,
  input logic                 acc_o,
  input logic                 stall_o,
  input logic [TW-1:0]        tag_o,
  input logic [FW-1:0]        inj,
  input logic [FW-1:0]        head,
  input logic [RW-1:0]        rsv,
  input logic signed [CW-1:0] credit
);
  p_tag_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o && !be_i) |-> (int'(tag_o) < W));

  p_not_head_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj != head);

  p_credit_floor_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(credit) >= 1 - int'(MAX_LEN)) && (int'(credit) <= int'(FRAME_FLITS)));

  p_acc_stall_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_o && stall_o));

  p_be_keeps_credit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && be_i && !shift_i) |=> $stable(credit) && $stable(inj));

  p_wrap_advance_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && head_i == inj) |=> (inj != $past(inj)) && (head == $past(head_i)));

  p_rsv_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(rsv));

  p_stall_no_move_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i && !shift_i) |=> $stable(inj) && $stable(credit));
endmodule

bind fcr_inject_ctrl fcr_inject_chk #(
  .W(W), .FRAME_FLITS(FRAME_FLITS), .MAX_LEN(MAX_LEN),
  .FW(FW), .TW(TW), .RW(RW), .CW(CW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .be_i(be_i),
  .shift_i(shift_i), .head_i(head_i), .acc_o(acc_o), .stall_o(stall_o),
  .tag_o(tag_o), .inj(inj_q), .head(head_q), .rsv(rsv_q), .credit(credit_q)
);

// File: tb/tb_fcr_inject_ctrl.sv
module tb_fcr_inject_ctrl;
  localparam int unsigned NV = 38;

  typedef struct packed {
    logic       req;
    logic       be;
    logic [3:0] len;
    logic       sh;
    logic [1:0] hd;
    logic       we;
    logic [4:0] wd;
    logic       ea;
    logic       es;
    logic [2:0] et;
    logic [3:0] rq;
  } vec_t;

  // W=4, RSV_INIT=5: start head 0, inj 1, credit 5
  localparam vec_t VEC [0:NV-1] = '{
    '{1,0,3,0,0,0,0, 1,0,1, 2},   // R2  credit 2
    '{1,0,9,0,0,0,0, 1,0,1, 9},   // R9  credit -7
    '{1,0,1,0,0,0,0, 0,1,0, 3},   // R3  step inj2 credit -2
    '{1,0,1,0,0,0,0, 0,1,0, 3},   // R3  step inj3 credit 3
    '{1,0,1,0,0,0,0, 1,0,3, 2},   // R2  credit 2
    '{1,0,2,0,0,0,0, 1,0,3, 2},   // R2  credit 0
    '{1,0,1,0,0,0,0, 0,1,0, 4},   // R4  next is head 0
    '{1,0,1,0,0,0,0, 0,1,0, 4},   // R4  still blocked
    '{1,1,4,0,0,0,0, 1,0,4, 7},   // R7  best effort
    '{0,0,0,1,1,0,0, 0,0,0, 5},   // R5  head 1
    '{1,0,1,0,0,0,0, 0,1,0, 3},   // R3  step inj0 credit 5
    '{1,0,5,0,0,0,0, 1,0,0, 2},   // R2  credit 0
    '{1,0,1,0,0,0,0, 0,1,0, 4},   // R4  next is head 1
    '{0,0,0,1,2,0,0, 0,0,0, 5},   // R5  head 2
    '{1,0,1,0,0,0,0, 0,1,0, 3},   // R3  step inj1 credit 5
    '{1,0,9,0,0,0,0, 1,0,1, 9},   // R9  credit -4
    '{1,0,1,0,0,0,0, 0,1,0, 4},   // R4  next is head 2
    '{0,0,0,1,3,0,0, 0,0,0, 5},   // R5  head 3
    '{1,0,1,0,0,0,0, 0,1,0, 3},   // R3  step inj2 credit 1
    '{1,0,1,0,0,0,0, 1,0,2, 6},   // R6  credit 0
    '{0,0,0,1,0,0,0, 0,0,0, 5},   // R5  head 0
    '{0,0,0,1,1,0,0, 0,0,0, 5},   // R5  head 1
    '{0,0,0,1,2,0,0, 0,0,0, 5},   // R5  head 2 = inj: inj3 credit 5
    '{1,0,1,0,0,0,0, 1,0,3, 5},   // R5  credit 4
    '{0,0,0,1,3,0,0, 0,0,0, 5},   // R5  wrap: inj0 credit min(5,9)=5
    '{1,0,5,0,0,0,0, 1,0,0, 5},   // R5  credit 0 proves clamp
    '{1,0,1,0,0,0,0, 0,1,0, 3},   // R3  step inj1 credit 5
    '{1,0,1,0,0,0,0, 1,0,1,10},   // R10 held request now taken, credit 4
    '{0,0,0,0,0,1,2, 0,0,0, 8},   // R8  write rsv 2 (pending)
    '{1,0,4,0,0,0,0, 1,0,1, 8},   // R8  credit 0
    '{1,0,1,0,0,0,0, 0,1,0, 8},   // R8  step with old rsv: credit 5
    '{1,0,2,0,0,0,0, 1,0,2, 8},   // R8  credit 3
    '{1,0,1,0,0,0,0, 1,0,2, 8},   // R8  credit 2 (new rsv would stall)
    '{0,0,0,1,0,0,0, 0,0,0, 8},   // R8  shift: rsv becomes 2
    '{1,0,2,0,0,0,0, 1,0,2, 8},   // R8  credit 0
    '{1,0,1,0,0,0,0, 0,1,0, 8},   // R8  step inj3 credit 2
    '{1,0,2,0,0,0,0, 1,0,3, 8},   // R8  credit 0
    '{1,0,1,0,0,0,0, 0,1,0, 8}    // R8  blocked, old rsv would accept
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0, be_i = 1'b0, shift_i = 1'b0, rsv_we_i = 1'b0;
  logic [3:0] len_i = '0;
  logic [1:0] head_i = '0;
  logic [4:0] rsv_i = '0;
  logic       acc_o, stall_o;
  logic [2:0] tag_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  fcr_inject_ctrl dut (
    .clk_i, .rst_ni, .req_i, .be_i, .len_i, .shift_i, .head_i,
    .rsv_we_i, .rsv_i, .acc_o, .stall_o, .tag_o
  );

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic drive(input logic rq, be, input logic [3:0] ln,
                       input logic sh, input logic [1:0] hd,
                       input logic we, input logic [4:0] wd);
    @(negedge clk_i);
    req_i = rq; be_i = be; len_i = ln; shift_i = sh; head_i = hd;
    rsv_we_i = we; rsv_i = wd;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    req_i = 0; be_i = 0; shift_i = 0; rsv_we_i = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    do_reset();
    // R1: idle after reset
    drive(0, 0, 0, 0, 0, 0, 0);
    chk("R1 idle acc", int'(acc_o), 0);
    chk("R1 idle stall", int'(stall_o), 0);

    for (int i = 0; i < NV; i++) begin
      string tg;
      drive(VEC[i].req, VEC[i].be, VEC[i].len, VEC[i].sh, VEC[i].hd,
            VEC[i].we, VEC[i].wd);
      tg = $sformatf("R%0d vec%0d", VEC[i].rq, i);
      chk({tg, " acc"}, int'(acc_o), int'(VEC[i].ea));
      chk({tg, " stall"}, int'(stall_o), int'(VEC[i].es));
      if (VEC[i].ea) chk({tg, " tag"}, int'(tag_o), int'(VEC[i].et));
    end

    // R1: fresh reset gives inj 1 and credit exactly 5
    do_reset();
    drive(1, 0, 5, 0, 0, 0, 0);
    chk("R1 first tag", int'(tag_o), 1);
    chk("R1 first acc", int'(acc_o), 1);
    drive(1, 0, 1, 0, 0, 0, 0);
    chk("R1 credit spent", int'(stall_o), 1);
    // R6 R7: best-effort tag uses the out-of-window value W=4
    drive(1, 1, 1, 0, 0, 0, 0);
    chk("R7 be acc", int'(acc_o), 1);
    chk("R6 be tag", int'(tag_o), 4);
    // R3: stall raised alone, then step lands on frame 2
    drive(1, 0, 1, 0, 0, 0, 0);
    chk("R3 step accepted", int'(acc_o), 1);
    chk("R3 step tag", int'(tag_o), 2);
    drive(0, 0, 0, 0, 0, 0, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule